// File: doc/BRIEF.md
# Banked-Mode Exception Entry Unit

This block keeps the live stack register (r29), link register (r30), program counter, status word and saved status word of a 32-bit core, together with one private bank per processor mode. A mode change stores the live stack, link and saved-status values into the bank of the mode being left and fetches those of the mode being entered. User mode and supervisor-user mode share a bank, so five banks serve six modes.

An exception request carries a cause code. The block looks up the target mode and the vector address, and raises the vector by a fixed high offset when the high-vector control input is set. In a single clock edge it swaps the banks, keeps the old status word as the saved status, writes the new mode field, masks interrupts, moves the old PC into the link register and loads the vector into the PC. A separate mode-switch request does only the bank swap and the mode-field update. A narrow write port lets the register-file side update the live copies.

Top module: `bx_entry_unit`

## Requirements
- R1: After reset r29, r30, the PC and the saved status read 0, the status word reads 0x00000093 (privileged mode 0x13 in bits 4:0, interrupt-disable bit 7 set), and done and error are low.
- R2: The mode field codes are user 0x10, supervisor-user 0x1F, privileged 0x13, trap 0x17, extension 0x1B and interrupt 0x12. Their bank indices are 0 for user and supervisor-user, then 1, 2, 3 and 4 for privileged, trap, extension and interrupt. A swap stores the live r29, r30 and saved status into the old mode's bank and loads all three from the new mode's bank.
- R3: A mode-switch request naming the current mode changes no register, and done still pulses.
- R4: A switch between user and supervisor-user leaves r29, r30 and the saved status unchanged, because both modes use the same bank.
- R5: Cause 0 enters privileged mode at 0x08. Cause 1 enters trap mode at 0x0C. Cause 2 enters trap mode at 0x10. Cause 3 enters interrupt mode at 0x18.
- R6: When the high-vector input is high at the request, 0xFFFF0000 is added to the vector.
- R7: An exception entry swaps banks only if the target mode differs from the current mode. The saved status then gets the old status word, bits 4:0 get the target mode, bit 7 is set, r30 gets the old PC and the PC gets the vector.
- R8: A cause code of 4 to 7, a current mode field that is not a listed code, or a requested mode that is not a listed code pulses the error output for one cycle and changes no register.
- R9: An accepted request shows its new state and a one-cycle done pulse in the cycle after the clock edge that samples it. Done and error are never high together.
- R10: A mode-switch request updates the banks and bits 4:0 only. The PC and the other status bits keep their values.
- R11: An exception request wins over a mode-switch request, and a mode-switch request wins over a write. A losing request in the same cycle is ignored.
- R12: A write with select 0, 1, 2, 3 or 4 loads r29, r30, the PC, the status word or the saved status, taking effect at the next edge. Selects 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_req_i | input | 1 | Exception entry request |
| exc_cause_i | input | 3 | Exception cause code |
| hivec_i | input | 1 | High-vector relocation enable |
| mode_req_i | input | 1 | Mode-switch request |
| mode_new_i | input | 5 | Requested mode code |
| wr_en_i | input | 1 | Live-register write enable |
| wr_sel_i | input | 3 | Live-register write select |
| wr_data_i | input | 32 | Live-register write data |
| sp_o | output | 32 | Live r29 |
| lr_o | output | 32 | Live r30 |
| pc_o | output | 32 | Program counter; holds the vector after an entry |
| status_o | output | 32 | Status word |
| saved_status_o | output | 32 | Live saved status word |
| done_o | output | 1 | Accepted entry or switch |
| err_o | output | 1 | Rejected entry or switch |

## Verification
The bench builds the unit with its default parameters: a high-vector offset of 0xFFFF0000 and a reset PC of 0. With these values every vector, with and without the offset, can be checked against the exact values in the requirements. Because the reset PC is zero, the link value after the first entry is the PC the bench wrote itself. Banks are observed only through the ports, by leaving a mode and coming back to it. The sequence reaches all five banks, the shared user bank, a trap entry taken while already in trap mode, every rejection case, and requests that arrive in the same cycle.

// File: rtl/bx_pkg.sv
package bx_pkg;
    localparam int XLEN       = 32;
    localparam int NUM_BANKS  = 5;
    localparam int BANK_IDX_W = $clog2(NUM_BANKS);
    localparam int MODE_W     = 5;
    localparam int CAUSE_W    = 3;
    localparam int SEL_W      = 3;
    localparam int IRQ_OFF    = 7;

    localparam logic [MODE_W-1:0] MODE_USER = 5'h10;
    localparam logic [MODE_W-1:0] MODE_SUSR = 5'h1F;
    localparam logic [MODE_W-1:0] MODE_PRIV = 5'h13;
    localparam logic [MODE_W-1:0] MODE_TRAP = 5'h17;
    localparam logic [MODE_W-1:0] MODE_EXTN = 5'h1B;
    localparam logic [MODE_W-1:0] MODE_INTR = 5'h12;

    localparam logic [SEL_W-1:0] SEL_SP  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_LR  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_PC  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_ST  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_BST = 3'd4;

    typedef struct packed {
        logic [XLEN-1:0] sp;
        logic [XLEN-1:0] lr;
        logic [XLEN-1:0] bst;
    } bank_t;

    typedef struct packed {
        logic [XLEN-1:0] sp;
        logic [XLEN-1:0] lr;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] st;
        logic [XLEN-1:0] bst;
        logic            done;
        logic            err;
    } core_t;
endpackage

// File: rtl/bx_mode_decode.sv
module bx_mode_decode
    import bx_pkg::*;
(
    input  logic [MODE_W-1:0]     mode_i,
    output logic [BANK_IDX_W-1:0] idx_o,
    output logic                  valid_o
);
    always_comb begin
        valid_o = 1'b1;
        idx_o   = '0;
        case (mode_i)
            MODE_USER, MODE_SUSR: idx_o = BANK_IDX_W'(0);
            MODE_PRIV:            idx_o = BANK_IDX_W'(1);
            MODE_TRAP:            idx_o = BANK_IDX_W'(2);
            MODE_EXTN:            idx_o = BANK_IDX_W'(3);
            MODE_INTR:            idx_o = BANK_IDX_W'(4);
            default:              valid_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/bx_vector_sel.sv
module bx_vector_sel
    import bx_pkg::*;
#(
    parameter logic [XLEN-1:0] HIVEC_OFFSET = 32'hFFFF_0000
) (
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic               hivec_i,
    output logic [XLEN-1:0]    vec_o,
    output logic [MODE_W-1:0]  mode_o,
    output logic               valid_o
);
    logic [XLEN-1:0] base;

    always_comb begin
        valid_o = 1'b1;
        base    = '0;
        mode_o  = MODE_PRIV;
        case (cause_i)
            3'd0: begin base = XLEN'(32'h08); mode_o = MODE_PRIV; end
            3'd1: begin base = XLEN'(32'h0C); mode_o = MODE_TRAP; end
            3'd2: begin base = XLEN'(32'h10); mode_o = MODE_TRAP; end
            3'd3: begin base = XLEN'(32'h18); mode_o = MODE_INTR; end
            default: valid_o = 1'b0;
        endcase
        vec_o = hivec_i ? (base + HIVEC_OFFSET) : base;
    end
endmodule

// File: rtl/bx_bank_store.sv
module bx_bank_store
    import bx_pkg::*;
#(
    parameter int NB = NUM_BANKS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [BANK_IDX_W-1:0] wr_idx_i,
    input  bank_t                 wr_data_i,
    input  logic [BANK_IDX_W-1:0] rd_idx_i,
    output bank_t                 rd_data_o
);
    bank_t bank_q [NB];
    bank_t bank_d [NB];

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NB; i++) begin
            bank_d[i] = (wr_en_i && wr_idx_i == BANK_IDX_W'(i)) ? wr_data_i : bank_q[i];
            if (rd_idx_i == BANK_IDX_W'(i)) rd_data_o = bank_q[i];
        end
    end

    for (genvar g = 0; g < NB; g++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bank_q[g] <= '0;
            else        bank_q[g] <= bank_d[g];
        end
    end
endmodule

// File: rtl/bx_entry_unit.sv
module bx_entry_unit
    import bx_pkg::*;
#(
    parameter logic [XLEN-1:0] HIVEC_OFFSET = 32'hFFFF_0000,
    parameter logic [XLEN-1:0] RESET_PC     = 32'h0000_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exc_req_i,
    input  logic [CAUSE_W-1:0] exc_cause_i,
    input  logic               hivec_i,
    input  logic               mode_req_i,
    input  logic [MODE_W-1:0]  mode_new_i,
    input  logic               wr_en_i,
    input  logic [SEL_W-1:0]   wr_sel_i,
    input  logic [XLEN-1:0]    wr_data_i,
    output logic [XLEN-1:0]    sp_o,
    output logic [XLEN-1:0]    lr_o,
    output logic [XLEN-1:0]    pc_o,
    output logic [XLEN-1:0]    status_o,
    output logic [XLEN-1:0]    saved_status_o,
    output logic               done_o,
    output logic               err_o
);
    localparam logic [XLEN-1:0] RESET_ST = XLEN'({1'b1, 2'b00, MODE_PRIV});

    core_t state_q, state_d;

    logic [BANK_IDX_W-1:0] cur_idx, tgt_idx;
    logic                  cur_ok, tgt_ok, cause_ok;
    logic [XLEN-1:0]       vec;
    logic [MODE_W-1:0]     vec_mode, tgt_mode;
    logic                  act, legal, swap;
    bank_t                 live_bank, rd_bank, fill;

    assign tgt_mode = exc_req_i ? vec_mode : mode_new_i;

    bx_mode_decode u_cur_dec (
        .mode_i  (state_q.st[MODE_W-1:0]),
        .idx_o   (cur_idx),
        .valid_o (cur_ok)
    );

    bx_mode_decode u_tgt_dec (
        .mode_i  (tgt_mode),
        .idx_o   (tgt_idx),
        .valid_o (tgt_ok)
    );

    bx_vector_sel #(.HIVEC_OFFSET(HIVEC_OFFSET)) u_vec (
        .cause_i (exc_cause_i),
        .hivec_i (hivec_i),
        .vec_o   (vec),
        .mode_o  (vec_mode),
        .valid_o (cause_ok)
    );

    assign live_bank = '{sp: state_q.sp, lr: state_q.lr, bst: state_q.bst};

    bx_bank_store #(.NB(NUM_BANKS)) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (swap),
        .wr_idx_i  (cur_idx),
        .wr_data_i (live_bank),
        .rd_idx_i  (tgt_idx),
        .rd_data_o (rd_bank)
    );

    always_comb begin
        act   = exc_req_i || mode_req_i;
        legal = cur_ok && tgt_ok && (!exc_req_i || cause_ok);
        swap  = act && legal && (tgt_mode != state_q.st[MODE_W-1:0]);
        // a shared bank returns what was just stored: the live copies
        fill  = (tgt_idx == cur_idx) ? live_bank : rd_bank;

        state_d      = state_q;
        state_d.done = 1'b0;
        state_d.err  = 1'b0;

        if (act) begin
            if (legal) begin
                state_d.done = 1'b1;
                if (swap) begin
                    state_d.sp  = fill.sp;
                    state_d.lr  = fill.lr;
                    state_d.bst = fill.bst;
                end
                state_d.st[MODE_W-1:0] = tgt_mode;
                if (exc_req_i) begin
                    state_d.bst         = state_q.st;
                    state_d.st[IRQ_OFF] = 1'b1;
                    state_d.lr          = state_q.pc;
                    state_d.pc          = vec;
                end
            end else begin
                state_d.err = 1'b1;
            end
        end else if (wr_en_i) begin
            case (wr_sel_i)
                SEL_SP:  state_d.sp  = wr_data_i;
                SEL_LR:  state_d.lr  = wr_data_i;
                SEL_PC:  state_d.pc  = wr_data_i;
                SEL_ST:  state_d.st  = wr_data_i;
                SEL_BST: state_d.bst = wr_data_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= '0;
            state_q.pc <= RESET_PC;
            state_q.st <= RESET_ST;
        end else begin
            state_q <= state_d;
        end
    end

    assign sp_o           = state_q.sp;
    assign lr_o           = state_q.lr;
    assign pc_o           = state_q.pc;
    assign status_o       = state_q.st;
    assign saved_status_o = state_q.bst;
    assign done_o         = state_q.done;
    assign err_o          = state_q.err;
endmodule

// File: rtl/bx_entry_checker.sv
module bx_entry_checker
    import bx_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               exc_req_i,
    input logic               hivec_i,
    input logic               mode_req_i,
    input logic [MODE_W-1:0]  mode_new_i,
    input logic [XLEN-1:0]    sp_o,
    input logic [XLEN-1:0]    lr_o,
    input logic [XLEN-1:0]    pc_o,
    input logic [XLEN-1:0]    status_o,
    input logic [XLEN-1:0]    saved_status_o,
    input logic               done_o,
    input logic               err_o
);
    p_done_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    p_err_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($stable(sp_o) && $stable(lr_o) && $stable(pc_o)
                   && $stable(status_o) && $stable(saved_status_o)));

    p_entry_save_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(exc_req_i)) |->
            (status_o[IRQ_OFF] && saved_status_o == $past(status_o) && lr_o == $past(pc_o)));

    p_hivec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(exc_req_i) && $past(hivec_i)) |-> (pc_o[XLEN-1:16] == 16'hFFFF));

    p_same_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(mode_req_i && !exc_req_i)
         && $past(mode_new_i) == $past(status_o[MODE_W-1:0]))
            |-> ($stable(sp_o) && $stable(lr_o) && $stable(saved_status_o)));

    p_switch_pc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(mode_req_i && !exc_req_i)) |->
            ($stable(pc_o) && $stable(status_o[XLEN-1:MODE_W])));
endmodule

bind bx_entry_unit bx_entry_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .exc_req_i      (exc_req_i),
    .hivec_i        (hivec_i),
    .mode_req_i     (mode_req_i),
    .mode_new_i     (mode_new_i),
    .sp_o           (sp_o),
    .lr_o           (lr_o),
    .pc_o           (pc_o),
    .status_o       (status_o),
    .saved_status_o (saved_status_o),
    .done_o         (done_o),
    .err_o          (err_o)
);

// File: tb/bx_entry_unit_tb_top.sv
module bx_entry_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req_i = 1'b0;
    logic [2:0]  exc_cause_i = '0;
    logic        hivec_i = 1'b0;
    logic        mode_req_i = 1'b0;
    logic [4:0]  mode_new_i = '0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_sel_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] sp_o, lr_o, pc_o, status_o, saved_status_o;
    logic        done_o, err_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bx_entry_unit dut_i (
        .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req_i), .exc_cause_i(exc_cause_i),
        .hivec_i(hivec_i), .mode_req_i(mode_req_i), .mode_new_i(mode_new_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .sp_o(sp_o), .lr_o(lr_o), .pc_o(pc_o), .status_o(status_o),
        .saved_status_o(saved_status_o), .done_o(done_o), .err_o(err_o)
    );

    typedef struct packed {
        logic [31:0] sp, lr, pc, st, bst;
        logic        done, err;
    } snap_t;

    snap_t exp_q[$];
    string tag_q[$];

    // reference model state
    logic [31:0] m_sp, m_lr, m_pc, m_st, m_bst;
    logic [31:0] mb_sp [5];
    logic [31:0] mb_lr [5];
    logic [31:0] mb_bs [5];

    function automatic int bank_of(input logic [4:0] m);
        case (m)
            5'h10, 5'h1F: return 0;
            5'h13: return 1;
            5'h17: return 2;
            5'h1B: return 3;
            5'h12: return 4;
            default: return -1;
        endcase
    endfunction

    task automatic model_swap(input logic [4:0] nm);
        int o, n;
        o = bank_of(m_st[4:0]);
        n = bank_of(nm);
        if (nm != m_st[4:0]) begin
            mb_sp[o] = m_sp; mb_lr[o] = m_lr; mb_bs[o] = m_bst;
            m_sp = mb_sp[n]; m_lr = mb_lr[n]; m_bst = mb_bs[n];
        end
    endtask

    task automatic compare(input snap_t a, input snap_t e, input string tag);
        n_checks++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s: got sp=%h lr=%h pc=%h st=%h bst=%h done=%b err=%b, expected sp=%h lr=%h pc=%h st=%h bst=%h done=%b err=%b",
                     tag, a.sp, a.lr, a.pc, a.st, a.bst, a.done, a.err,
                     e.sp, e.lr, e.pc, e.st, e.bst, e.done, e.err);
        end
    endtask

    // driver: one request, expected result queued for the monitor
    task automatic drive(input bit ex, input logic [2:0] cause, input bit hv,
                         input bit ms, input logic [4:0] mn,
                         input bit we, input logic [2:0] ws, input logic [31:0] wd,
                         input string tag);
        snap_t e;
        bit ok;
        logic [31:0] vec;
        logic [4:0]  tm;
        @(negedge clk);
        exc_req_i = ex; exc_cause_i = cause; hivec_i = hv;
        mode_req_i = ms; mode_new_i = mn;
        wr_en_i = we; wr_sel_i = ws; wr_data_i = wd;
        e.done = 1'b0; e.err = 1'b0;
        if (ex) begin
            ok = 1'b1;
            case (cause)
                3'd0: begin vec = 32'h08; tm = 5'h13; end
                3'd1: begin vec = 32'h0C; tm = 5'h17; end
                3'd2: begin vec = 32'h10; tm = 5'h17; end
                3'd3: begin vec = 32'h18; tm = 5'h12; end
                default: begin vec = 32'h0; tm = 5'h13; ok = 1'b0; end
            endcase
            if (hv) vec = vec + 32'hFFFF_0000;
            if (bank_of(m_st[4:0]) < 0) ok = 1'b0;
            if (ok) begin
                model_swap(tm);
                m_bst = m_st;
                m_st  = {m_st[31:8], 1'b1, m_st[6:5], tm};
                m_lr  = m_pc;
                m_pc  = vec;
                e.done = 1'b1;
            end else e.err = 1'b1;
        end else if (ms) begin
            if (bank_of(m_st[4:0]) >= 0 && bank_of(mn) >= 0) begin
                model_swap(mn);
                m_st[4:0] = mn;
                e.done = 1'b1;
            end else e.err = 1'b1;
        end else if (we) begin
            case (ws)
                3'd0: m_sp = wd;
                3'd1: m_lr = wd;
                3'd2: m_pc = wd;
                3'd3: m_st = wd;
                3'd4: m_bst = wd;
                default: ;
            endcase
        end
        e.sp = m_sp; e.lr = m_lr; e.pc = m_pc; e.st = m_st; e.bst = m_bst;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        exc_req_i = 1'b0; mode_req_i = 1'b0; wr_en_i = 1'b0;
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d, input string tag);
        drive(0, 3'd0, 0, 0, 5'h0, 1, s, d, tag);
    endtask
    task automatic sw(input logic [4:0] m, input string tag);
        drive(0, 3'd0, 0, 1, m, 0, 3'd0, 32'h0, tag);
    endtask
    task automatic ex(input logic [2:0] c, input bit hv, input string tag);
        drive(1, c, hv, 0, 5'h0, 0, 3'd0, 32'h0, tag);
    endtask

    // monitor: compares each queued item after the edge that produced it
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            snap_t a;
            a = '{sp: sp_o, lr: lr_o, pc: pc_o, st: status_o, bst: saved_status_o,
                  done: done_o, err: err_o};
            compare(a, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        m_sp = 0; m_lr = 0; m_pc = 0; m_st = 32'h93; m_bst = 0;
        for (int i = 0; i < 5; i++) begin mb_sp[i] = 0; mb_lr[i] = 0; mb_bs[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        compare('{sp: sp_o, lr: lr_o, pc: pc_o, st: status_o, bst: saved_status_o,
                  done: done_o, err: err_o},
                '{sp: 0, lr: 0, pc: 0, st: 32'h93, bst: 0, done: 0, err: 0}, "R1 reset");
        // R12 write port
        wr(3'd0, 32'hA1A1_0001, "R12 sp write");
        wr(3'd1, 32'hB1B1_0002, "R12 lr write");
        wr(3'd4, 32'hC1C1_0003, "R12 saved status write");
        wr(3'd2, 32'h0000_0100, "R12 pc write");
        wr(3'd6, 32'hDEAD_BEEF, "R12 unused select ignored");
        // R2 / R10 bank swap
        sw(5'h17, "R2 R10 priv to trap");
        wr(3'd0, 32'hD2D2_0004, "R12 sp write in trap");
        sw(5'h13, "R2 trap back to priv");
        sw(5'h13, "R3 same mode");
        sw(5'h17, "R2 trap bank kept");
        sw(5'h1B, "R2 trap to extension");
        wr(3'd1, 32'hE3E3_0005, "R12 lr write in extension");
        sw(5'h13, "R2 extension to priv");
        sw(5'h1B, "R2 extension bank kept");
        sw(5'h13, "R2 back to priv");
        // R4 shared bank
        sw(5'h10, "R2 priv to user");
        wr(3'd0, 32'hE0E0_0006, "R12 sp write in user");
        sw(5'h1F, "R4 user to supervisor-user");
        sw(5'h10, "R4 supervisor-user to user");
        sw(5'h13, "R2 user to priv");
        // R5 R6 R7 exceptions
        ex(3'd3, 0, "R5 R7 interrupt entry");
        ex(3'd1, 1, "R5 R6 instruction trap high vector");
        ex(3'd2, 0, "R5 R7 data trap while in trap");
        ex(3'd0, 1, "R5 R6 privileged entry high vector");
        sw(5'h10, "R10 switch to user");
        ex(3'd3, 0, "R7 interrupt entry from user");
        sw(5'h10, "R2 interrupt back to user");
        // R8 rejections
        ex(3'd5, 0, "R8 bad cause");
        ex(3'd7, 1, "R8 bad cause high vector");
        sw(5'h00, "R8 bad requested mode");
        wr(3'd3, 32'h0000_0001, "R12 status write illegal mode");
        ex(3'd0, 0, "R8 bad current mode entry");
        sw(5'h13, "R8 bad current mode switch");
        wr(3'd3, 32'h0000_0013, "R12 status restore");
        // R11 priority
        drive(1, 3'd1, 0, 1, 5'h1B, 1, 3'd0, 32'h1111_2222, "R11 exception beats switch and write");
        drive(0, 3'd0, 0, 1, 5'h12, 1, 3'd0, 32'h3333_4444, "R11 switch beats write");
        sw(5'h13, "R2 interrupt to priv");
        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule